// File: doc/BRIEF.md
# Flash Block Lock-State Manager

This block keeps the write-protection state of a parameterised set of flash erase blocks. Each block is unlocked, locked or locked-down. A command port takes the second code of an already sequenced protection command (lock, unlock or lock-down) together with the index of the target block. The block applies that code to the stored state of the target block. An active-low write-protect input decides whether a locked-down block may still be released.

A query port returns the state of any block as a 2-bit code. Program and erase requests are checked against the state of their target block. A request aimed at a protected block is refused, and the refusal shows as a one-clock error pulse. When reset releases, every block is locked. An upstream sequencer handles recognising the setup cycle and timing the bus. The manager only sees the decoded second code.

Top module: `blk_lock_mgr`

## Requirements
- R1: While `rst_n` is low at a clock edge, every block is set to locked. After release, every block reads locked on the query port. This holds whatever state a block had before. Query codes are 2'b00 unlocked, 2'b01 locked and 2'b11 locked-down.
- R2: A strobe with code 8'h01 locks the addressed block. The query shows 2'b01 from the clock edge that samples the strobe. The other blocks keep their state.
- R3: A strobe with code 8'hD0 makes a locked block unlocked (2'b00).
- R4: A strobe with code 8'h2F puts the addressed block in locked-down (2'b11), whatever its state was before.
- R5: An unlock code (8'hD0) sent to a locked-down block while `wp_n` is 0 has no effect. The block stays 2'b11.
- R6: An unlock code sent to a locked-down block while `wp_n` is 1 makes the block unlocked (2'b00).
- R7: A lock code sent to a locked-down block leaves it locked-down (2'b11).
- R8: Any code other than 8'h01, 8'hD0 and 8'h2F is dropped. Examples are 8'h60, 8'hFF and 8'h00. No block changes state.
- R9: A program or erase request (`op_valid`) to a locked or locked-down block raises `lock_err` for exactly the one cycle after the edge that samples the request. A request to an unlocked block leaves `lock_err` low.
- R10: A valid code has no effect while `cmd_valid` is low.
- R11: When a request and a command hit the same block in the same cycle, the request is judged against the state before the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; on release all blocks are locked |
| wp_n | input | 1 | Active-low write protect; when low, locked-down blocks stay locked-down |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Second code of the protection sequence |
| cmd_blk | input | IDX_W | Target block index of the command |
| op_valid | input | 1 | Program or erase request strobe |
| op_blk | input | IDX_W | Target block index of the request |
| qry_blk | input | IDX_W | Block index to query |
| qry_state | output | 2 | State of the queried block |
| lock_err | output | 1 | One-cycle pulse: the request was refused |

## Verification
The hardest case to reach from the ports is a locked-down block being released. It needs a lock-down first, then a refused unlock with write-protect low, then a successful unlock after write-protect rises. Each step is checked on the query port. A second hard case is a request and a state-changing command that land on the same block in the same cycle. The stimulus drives both strobes from one task at the same falling edge, in both directions: lock over unlocked, and unlock over locked. This shows that the refusal uses the old state.

// File: rtl/blk_lock_pkg.sv
// Shared types for the block lock-state manager.
// Assumes: state encodings are visible on the query port and must stay fixed.
package blk_lock_pkg;
    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'b00,
        ST_LOCKED   = 2'b01,
        ST_LDOWN    = 2'b11
    } lk_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOCK   = 2'b01,
        ACT_UNLOCK = 2'b10,
        ACT_LDOWN  = 2'b11
    } lk_act_e;

    localparam int          CODE_W      = 8;
    localparam logic [7:0]  CODE_LOCK   = 8'h01;
    localparam logic [7:0]  CODE_UNLOCK = 8'hD0;
    localparam logic [7:0]  CODE_LDOWN  = 8'h2F;
endpackage

// File: rtl/blk_lock_decode.sv
// Turns the strobed second protection code into an action.
// Assumes: the setup cycle was already recognised upstream; unknown codes
// become ACT_NONE so the sequence is dropped.
module blk_lock_decode
    import blk_lock_pkg::*;
(
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    output lk_act_e           act
);
    // Map the code to an action; anything unrecognised is no action.
    always_comb begin
        act = ACT_NONE;
        if (valid) begin
            case (code)
                CODE_LOCK:   act = ACT_LOCK;
                CODE_UNLOCK: act = ACT_UNLOCK;
                CODE_LDOWN:  act = ACT_LDOWN;
                default:     act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/blk_lock_cell.sv
// Lock state of a single erase block.
// Assumes: hit is high only for a decoded action aimed at this block;
// wp_n is sampled at the same edge as the command.
module blk_lock_cell
    import blk_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  lk_act_e   act,
    input  logic      wp_n,
    output lk_state_e st
);
    lk_state_e st_q;
    lk_state_e st_d;

    // Next-state rules; locked-down is left only by an unlock with wp_n high.
    always_comb begin
        st_d = st_q;
        if (hit) begin
            case (act)
                ACT_LOCK:   if (st_q != ST_LDOWN) st_d = ST_LOCKED;
                ACT_UNLOCK: if (st_q != ST_LDOWN || wp_n) st_d = ST_UNLOCKED;
                ACT_LDOWN:  st_d = ST_LDOWN;
                default:    st_d = st_q;
            endcase
        end
    end

    // State register; reset forces the block locked.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOCKED;
        else        st_q <= st_d;
    end

    assign st = st_q;

    p_reset_locked_r1: assert property (@(posedge clk)
        !rst_n |=> st_q == ST_LOCKED);
    p_ldown_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit && act == ACT_LDOWN |=> st_q == ST_LDOWN);
    p_unlock_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && act == ACT_UNLOCK && st_q == ST_LDOWN && !wp_n |=> st_q == ST_LDOWN);
    p_wp_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit && act == ACT_UNLOCK && wp_n |=> st_q == ST_UNLOCKED);
    p_ldown_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_LDOWN && !(hit && act == ACT_UNLOCK && wp_n) |=> st_q == ST_LDOWN);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(st_q));
endmodule

// File: rtl/blk_lock_guard.sv
// Refuses program/erase requests to protected blocks with a one-cycle pulse.
// Assumes: tgt_state is the state of the target block before any command
// applied in the same cycle.
module blk_lock_guard
    import blk_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_valid,
    input  lk_state_e tgt_state,
    output logic      lock_err
);
    // Register the refusal so it lasts exactly one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_err <= 1'b0;
        else        lock_err <= op_valid && (tgt_state != ST_UNLOCKED);
    end

    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && tgt_state != ST_UNLOCKED |=> lock_err);
    p_allow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && tgt_state == ST_UNLOCKED |=> !lock_err);
    p_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !lock_err);
endmodule

// File: rtl/blk_lock_mgr.sv
// Per-block write-protection manager: applies decoded lock codes, answers
// queries and refuses requests to protected blocks.
// Assumes: indices at or above NUM_BLK read as locked and are never changed.
module blk_lock_mgr
    import blk_lock_pkg::*;
#(
    parameter  int NUM_BLK = 16,
    localparam int IDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [IDX_W-1:0]  cmd_blk,
    input  logic              op_valid,
    input  logic [IDX_W-1:0]  op_blk,
    input  logic [IDX_W-1:0]  qry_blk,
    output logic [1:0]        qry_state,
    output logic              lock_err
);
    lk_act_e   act;
    lk_state_e st [NUM_BLK];
    lk_state_e op_state;
    lk_state_e q_state;

    blk_lock_decode u_dec (
        .valid (cmd_valid),
        .code  (cmd_code),
        .act   (act)
    );

    // One lock cell per erase block.
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_cell
        logic hit;
        assign hit = (act != ACT_NONE) && (cmd_blk == IDX_W'(i));
        blk_lock_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit),
            .act   (act),
            .wp_n  (wp_n),
            .st    (st[i])
        );
    end

    // Query read; out-of-range indices report locked.
    always_comb begin
        q_state = ST_LOCKED;
        for (int i = 0; i < NUM_BLK; i++)
            if (qry_blk == IDX_W'(i)) q_state = st[i];
    end
    assign qry_state = q_state;

    // State of the request target, taken before this cycle's command.
    always_comb begin
        op_state = ST_LOCKED;
        for (int i = 0; i < NUM_BLK; i++)
            if (op_blk == IDX_W'(i)) op_state = st[i];
    end

    blk_lock_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .tgt_state (op_state),
        .lock_err  (lock_err)
    );

    p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_state == ST_UNLOCKED |=> !lock_err);
endmodule

// File: tb/sim_blk_lock_mgr.sv
module sim_blk_lock_mgr;
    localparam int NB = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic [IW-1:0] cmd_blk = '0;
    logic          op_valid = 1'b0;
    logic [IW-1:0] op_blk = '0;
    logic [IW-1:0] qry_blk = '0;
    logic [1:0]    qry_state;
    logic          lock_err;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    blk_lock_mgr #(.NUM_BLK(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_blk(cmd_blk),
        .op_valid(op_valid), .op_blk(op_blk), .qry_blk(qry_blk),
        .qry_state(qry_state), .lock_err(lock_err)
    );

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_st(string tag, int b, logic [1:0] exp);
        qry_blk = IW'(b);
        #1;
        chk(tag, qry_state, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(logic [7:0] code, int b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_blk = IW'(b);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic req(int b, logic exp);
        @(negedge clk);
        op_valid = 1'b1; op_blk = IW'(b);
        @(negedge clk);
        op_valid = 1'b0;
        #1 chk("R9 err pulse", {1'b0, lock_err}, {1'b0, exp});
        @(negedge clk);
        #1 chk("R9 err one cycle", {1'b0, lock_err}, 2'b00);
    endtask

    task automatic t_reset();
        do_reset();
        for (int b = 0; b < NB; b++) chk_st("R1 reset locked", b, 2'b01);
        #1 chk("R1 err idle", {1'b0, lock_err}, 2'b00);
    endtask

    task automatic t_lock_unlock();
        send(8'hD0, 3);
        chk_st("R3 unlock", 3, 2'b00);
        chk_st("R2 neighbour", 4, 2'b01);
        send(8'h01, 3);
        chk_st("R2 lock", 3, 2'b01);
        send(8'hD0, 7);
        chk_st("R3 unlock b7", 7, 2'b00);
        chk_st("R2 b3 untouched", 3, 2'b01);
    endtask

    task automatic t_lockdown();
        wp_n = 1'b0;
        send(8'h2F, 7);
        chk_st("R4 ldown from unlocked", 7, 2'b11);
        send(8'h2F, 9);
        chk_st("R4 ldown from locked", 9, 2'b11);
        send(8'hD0, 9);
        chk_st("R5 unlock ignored", 9, 2'b11);
        send(8'h01, 9);
        chk_st("R7 lock on ldown", 9, 2'b11);
        req(9, 1'b1);
    endtask

    task automatic t_wp_release();
        wp_n = 1'b1;
        send(8'h01, 7);
        chk_st("R7 lock on ldown wp high", 7, 2'b11);
        send(8'hD0, 7);
        chk_st("R6 unlock released", 7, 2'b00);
        wp_n = 1'b0;
    endtask

    task automatic t_bad_codes();
        send(8'hD0, 12);
        send(8'h60, 12);
        chk_st("R8 code 60 dropped", 12, 2'b00);
        send(8'hFF, 12);
        chk_st("R8 code FF dropped", 12, 2'b00);
        send(8'h00, 1);
        chk_st("R8 code 00 dropped", 1, 2'b01);
        send(8'h02, 9);
        chk_st("R8 ldown kept", 9, 2'b11);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 8'h01; cmd_blk = IW'(12);
        @(negedge clk);
        chk_st("R10 no strobe", 12, 2'b00);
    endtask

    task automatic t_ops();
        req(12, 1'b0);
        req(2, 1'b1);
        @(negedge clk);
        op_valid = 1'b1; op_blk = IW'(2);
        @(negedge clk);
        op_blk = IW'(12);
        #1 chk("R9 back-to-back 1", {1'b0, lock_err}, 2'b01);
        @(negedge clk);
        op_valid = 1'b0;
        #1 chk("R9 back-to-back 2", {1'b0, lock_err}, 2'b00);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'h01; cmd_blk = IW'(12);
        op_valid = 1'b1; op_blk = IW'(12);
        @(negedge clk);
        cmd_valid = 1'b0; op_valid = 1'b0;
        #1 chk("R11 lock+req old unlocked", {1'b0, lock_err}, 2'b00);
        chk_st("R11 lock applied", 12, 2'b01);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'hD0; cmd_blk = IW'(5);
        op_valid = 1'b1; op_blk = IW'(5);
        @(negedge clk);
        cmd_valid = 1'b0; op_valid = 1'b0;
        #1 chk("R11 unlock+req old locked", {1'b0, lock_err}, 2'b01);
        chk_st("R11 unlock applied", 5, 2'b00);
    endtask

    task automatic t_reset_again();
        do_reset();
        chk_st("R1 ldown cleared", 9, 2'b01);
        chk_st("R1 unlocked cleared", 5, 2'b01);
    endtask

    initial begin
        t_reset();
        t_lock_unlock();
        t_lockdown();
        t_wp_release();
        t_bad_codes();
        t_no_strobe();
        t_ops();
        t_same_cycle();
        t_reset_again();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule